// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the software-visible register bank of one general-purpose I/O port of 16 pins. It sits on a simple 32-bit register bus with one-cycle requests. It stores the per-pin configuration: direction mode, output driver type, slew speed and pull selection. It also stores the output data word. It exports all of these to a separate pin resolver, and it returns the resolved pin levels, which the resolver supplies, when the input word is read.

The output data can be changed in two atomic ways. A combined word sets and clears bits in one write, and a set wins over a clear on the same pin. A separate word only clears bits. Both of these words read back as zero. The lock, alternate-function and analog-switch words are plain storage and have no effect on the exported state. After every write that can change pin behaviour, the bank emits a one-cycle update pulse so that the resolver recomputes the pins.

Top module: `gpio_regbank`

## Requirements
- R1: After reset, mode_o, speed_o and pull_o equal the instance parameters MODE_RST, SPEED_RST and PULL_RST. All other stored words are zero, and update_o and rvalid_o are low.
- R2: Word offsets are as follows: mode 0x00, driver type 0x04, speed 0x08, pull 0x0C, pin input 0x10, output data 0x14, set/clear 0x18, lock 0x1C, alternate function low 0x20 and high 0x24, clear-only 0x28, analog switch 0x2C. Mode, speed, pull and both alternate-function words store and return all 32 bits. Mode and pull use 2 bits per pin, with pin n at bits 2n+1:2n.
- R3: A write to 0x18 sets the output bits selected by wdata bits 15:0 and clears those selected by bits 31:16. When a pin is selected in both halves, it ends up set.
- R4: A write to 0x28 clears the output bits selected by wdata bits 15:0 and ignores bits 31:16.
- R5: Reads of 0x18 and 0x28 return zero.
- R6: A read of 0x10 returns idata_i as sampled in the request cycle. A write to 0x10 changes no state and raises no update pulse.
- R7: Writes to the driver type, output data, lock and analog switch words keep only bits 15:0, and these words read back with bits 31:16 at zero.
- R8: An access whose address has bits 1:0 not equal to zero, or whose word index is past 0x2C, reads zero and changes no state.
- R9: update_o is high for exactly the one cycle after a write to mode, driver type, pull, output data, set/clear or clear-only. It stays low after any other access.
- R10: rvalid_o is high in the cycle after each read request. In that cycle, rdata_o holds the addressed value as it stood in the request cycle.
- R11: Writes to speed, lock, alternate-function and analog-switch words leave mode_o, otype_o, pull_o and odata_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address within the port window |
| wdata_i | input | 32 | Write data |
| idata_i | input | 16 | Resolved pin levels from the resolver |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid |
| mode_o | output | 32 | Per-pin mode, 2 bits each |
| otype_o | output | 16 | Per-pin driver type |
| speed_o | output | 32 | Per-pin speed, 2 bits each |
| pull_o | output | 32 | Per-pin pull, 2 bits each |
| odata_o | output | 16 | Output data word |
| update_o | output | 1 | Recompute pulse for the resolver |

## Verification
The properties assume the following of the bus: req_i and we_i are driven low while reset is asserted and on the first edge after release, and each request lasts one cycle with a stable address and data. The bench meets this by driving every bus input from tasks that hold a request for exactly one cycle and then return it to idle. It also keeps the request line low from time zero through reset. idata_i is changed only between requests, so the captured input word is defined.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;
  localparam int NUM_REGS = 12;

  // word index = byte offset >> 2; the order is the bus map
  typedef enum logic [3:0] {
    SEL_MODE  = 4'd0,
    SEL_OTYPE = 4'd1,
    SEL_SPEED = 4'd2,
    SEL_PULL  = 4'd3,
    SEL_IDATA = 4'd4,
    SEL_ODATA = 4'd5,
    SEL_SETCLR= 4'd6,
    SEL_LOCK  = 4'd7,
    SEL_AFLO  = 4'd8,
    SEL_AFHI  = 4'd9,
    SEL_CLR   = 4'd10,
    SEL_ASW   = 4'd11
  } reg_sel_e;

  // writes that change pin behaviour
  localparam logic [NUM_REGS-1:0] UPD_MASK =
      NUM_REGS'((1 << SEL_MODE) | (1 << SEL_OTYPE) | (1 << SEL_PULL) |
                (1 << SEL_ODATA) | (1 << SEL_SETCLR) | (1 << SEL_CLR));
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_regbank_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output reg_sel_e          rd_sel_o,
  output logic [NUM_REGS-1:0] wr_sel_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  assign idx      = addr_i[ADDR_W-1:2];
  assign hit_o    = (addr_i[1:0] == 2'b00) && (idx < IDX_W'(NUM_REGS));
  assign rd_sel_o = reg_sel_e'(idx[3:0]);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wsel
    assign wr_sel_o[g] = req_i & we_i & hit_o & (idx == IDX_W'(g));
  end
endmodule

// File: rtl/gpio_word_reg.sv
module gpio_word_reg #(
  parameter int           W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/gpio_odata_unit.sv
module gpio_odata_unit #(
  parameter int PINS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_direct_i,
  input  logic              wr_setclr_i,
  input  logic              wr_clr_i,
  input  logic [2*PINS-1:0] wdata_i,
  output logic [PINS-1:0]   q_o
);
  logic [PINS-1:0] set_m, clr_m, nxt;

  assign set_m = wdata_i[PINS-1:0];
  assign clr_m = wdata_i[2*PINS-1:PINS];

  always_comb begin
    nxt = q_o;
    if (wr_direct_i)      nxt = set_m;
    else if (wr_setclr_i) nxt = (q_o & ~clr_m) | set_m; // set applied last: wins
    else if (wr_clr_i)    nxt = q_o & ~set_m;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_regbank_pkg::*;
#(
  parameter int                PINS      = 16,
  parameter int                ADDR_W    = 10,
  parameter logic [2*PINS-1:0] MODE_RST  = '0,
  parameter logic [2*PINS-1:0] SPEED_RST = '0,
  parameter logic [2*PINS-1:0] PULL_RST  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2*PINS-1:0] wdata_i,
  input  logic [PINS-1:0]   idata_i,
  output logic [2*PINS-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [2*PINS-1:0] mode_o,
  output logic [PINS-1:0]   otype_o,
  output logic [2*PINS-1:0] speed_o,
  output logic [2*PINS-1:0] pull_o,
  output logic [PINS-1:0]   odata_o,
  output logic              update_o
);
  localparam int DW = 2 * PINS;

  logic                hit;
  reg_sel_e            rd_sel;
  logic [NUM_REGS-1:0] wr_sel;
  logic [PINS-1:0]     lock_q, asw_q;
  logic [DW-1:0]       aflo_q, afhi_q;
  logic [DW-1:0]       rd_val;

  gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .req_i, .we_i, .addr_i,
    .hit_o(hit), .rd_sel_o(rd_sel), .wr_sel_o(wr_sel)
  );

  gpio_word_reg #(.W(DW), .RST(MODE_RST)) u_mode (
    .clk_i, .rst_ni, .we_i(wr_sel[SEL_MODE]), .d_i(wdata_i), .q_o(mode_o));
  gpio_word_reg #(.W(PINS), .RST('0)) u_otype (
    .clk_i, .rst_ni, .we_i(wr_sel[SEL_OTYPE]), .d_i(wdata_i[PINS-1:0]), .q_o(otype_o));
  gpio_word_reg #(.W(DW), .RST(SPEED_RST)) u_speed (
    .clk_i, .rst_ni, .we_i(wr_sel[SEL_SPEED]), .d_i(wdata_i), .q_o(speed_o));
  gpio_word_reg #(.W(DW), .RST(PULL_RST)) u_pull (
    .clk_i, .rst_ni, .we_i(wr_sel[SEL_PULL]), .d_i(wdata_i), .q_o(pull_o));

  // storage-only words
  gpio_word_reg #(.W(PINS), .RST('0)) u_lock (
    .clk_i, .rst_ni, .we_i(wr_sel[SEL_LOCK]), .d_i(wdata_i[PINS-1:0]), .q_o(lock_q));
  gpio_word_reg #(.W(DW), .RST('0)) u_aflo (
    .clk_i, .rst_ni, .we_i(wr_sel[SEL_AFLO]), .d_i(wdata_i), .q_o(aflo_q));
  gpio_word_reg #(.W(DW), .RST('0)) u_afhi (
    .clk_i, .rst_ni, .we_i(wr_sel[SEL_AFHI]), .d_i(wdata_i), .q_o(afhi_q));
  gpio_word_reg #(.W(PINS), .RST('0)) u_asw (
    .clk_i, .rst_ni, .we_i(wr_sel[SEL_ASW]), .d_i(wdata_i[PINS-1:0]), .q_o(asw_q));

  gpio_odata_unit #(.PINS(PINS)) u_odata (
    .clk_i, .rst_ni,
    .wr_direct_i(wr_sel[SEL_ODATA]),
    .wr_setclr_i(wr_sel[SEL_SETCLR]),
    .wr_clr_i   (wr_sel[SEL_CLR]),
    .wdata_i,
    .q_o(odata_o)
  );

  always_comb begin
    rd_val = '0;
    unique case (rd_sel)
      SEL_MODE:  rd_val = mode_o;
      SEL_OTYPE: rd_val = {{PINS{1'b0}}, otype_o};
      SEL_SPEED: rd_val = speed_o;
      SEL_PULL:  rd_val = pull_o;
      SEL_IDATA: rd_val = {{PINS{1'b0}}, idata_i};
      SEL_ODATA: rd_val = {{PINS{1'b0}}, odata_o};
      SEL_LOCK:  rd_val = {{PINS{1'b0}}, lock_q};
      SEL_AFLO:  rd_val = aflo_q;
      SEL_AFHI:  rd_val = afhi_q;
      SEL_ASW:   rd_val = {{PINS{1'b0}}, asw_q};
      default:   rd_val = '0; // set/clear words and holes
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      update_o <= 1'b0;
    end else begin
      rvalid_o <= req_i & ~we_i;
      update_o <= |(wr_sel & UPD_MASK);
      if (req_i && !we_i) rdata_o <= hit ? rd_val : '0;
    end
  end
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
  parameter int PINS   = 16,
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [2*PINS-1:0] wdata_i,
  input logic [2*PINS-1:0] rdata_o,
  input logic              rvalid_o,
  input logic [2*PINS-1:0] mode_o,
  input logic [PINS-1:0]   otype_o,
  input logic [2*PINS-1:0] pull_o,
  input logic [PINS-1:0]   odata_o,
  input logic              update_o
);
  logic wr, rd, wr_setclr, wr_clr, wr_idata, wr_quiet, rd_zero;
  assign wr        = req_i & we_i;
  assign rd        = req_i & ~we_i;
  assign wr_setclr = wr && addr_i == ADDR_W'(8'h18);
  assign wr_clr    = wr && addr_i == ADDR_W'(8'h28);
  assign wr_idata  = wr && addr_i == ADDR_W'(8'h10);
  assign wr_quiet  = wr && (addr_i[1:0] != 2'b00 || addr_i > ADDR_W'(8'h2C));
  assign rd_zero   = rd && (addr_i == ADDR_W'(8'h18) || addr_i == ADDR_W'(8'h28));

  // R3
  a_r3_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_setclr |=> odata_o == (($past(odata_o) & ~$past(wdata_i[2*PINS-1:PINS]))
                              | $past(wdata_i[PINS-1:0])));
  // R4
  a_r4_clear_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> odata_o == ($past(odata_o) & ~$past(wdata_i[PINS-1:0])));
  // R5
  a_r5_zero_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_zero |=> rdata_o == '0);
  // R6
  a_r6_idata_wr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_idata |=> $stable(mode_o) && $stable(otype_o) && $stable(pull_o)
                 && $stable(odata_o) && !update_o);
  // R8
  a_r8_bad_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_quiet |=> $stable(mode_o) && $stable(otype_o) && $stable(pull_o)
                 && $stable(odata_o) && !update_o);
  // R9
  a_r9_update_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> $past(wr));
  // R10
  a_r10_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o == $past(rd));
endmodule

bind gpio_regbank gpio_regbank_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o, .rvalid_o,
  .mode_o, .otype_o, .pull_o, .odata_o, .update_o
);

// File: tb/tb_gpio_regbank.sv
`timescale 1ns/1ps
module tb_gpio_regbank;
  localparam int          PINS = 16;
  localparam int          AW   = 10;
  localparam logic [31:0] MR   = 32'hABFF_FFFF;
  localparam logic [31:0] SR   = 32'h0C00_0000;
  localparam logic [31:0] PR   = 32'h6400_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] idata = '0;
  logic [31:0] rdata, mode, speed, pull;
  logic [15:0] otype, odata;
  logic rvalid, update;

  always #4 clk = ~clk;

  gpio_regbank #(.PINS(PINS), .ADDR_W(AW), .MODE_RST(MR), .SPEED_RST(SR),
                 .PULL_RST(PR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .idata_i(idata), .rdata_o(rdata), .rvalid_o(rvalid),
    .mode_o(mode), .otype_o(otype), .speed_o(speed), .pull_o(pull),
    .odata_o(odata), .update_o(update));

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // model of the stored words, built from the requirements
  logic [31:0] m_mode = MR, m_speed = SR, m_pull = PR, m_aflo = '0, m_afhi = '0;
  logic [15:0] m_otype = '0, m_odata = '0, m_lock = '0, m_asw = '0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(logic [AW-1:0] a);
    if (a[1:0] != 0) return '0;
    case (a)
      10'h00: return m_mode;
      10'h04: return {16'h0, m_otype};
      10'h08: return m_speed;
      10'h0C: return m_pull;
      10'h10: return {16'h0, idata};
      10'h14: return {16'h0, m_odata};
      10'h1C: return {16'h0, m_lock};
      10'h20: return m_aflo;
      10'h24: return m_afhi;
      10'h2C: return {16'h0, m_asw};
      default: return '0;
    endcase
  endfunction

  task automatic chk_ports(string tag);
    check({tag, " mode_o"},  mode,  m_mode);
    check({tag, " otype_o"}, {16'h0, otype}, {16'h0, m_otype});
    check({tag, " speed_o"}, speed, m_speed);
    check({tag, " pull_o"},  pull,  m_pull);
    check({tag, " odata_o"}, {16'h0, odata}, {16'h0, m_odata});
  endtask

  // driver: one-cycle write, then checks the update pulse (R9)
  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    bit upd = 1'b0;
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    if (a[1:0] == 0) case (a)
      10'h00: begin m_mode  = d;        upd = 1; end
      10'h04: begin m_otype = d[15:0];  upd = 1; end
      10'h08: m_speed = d;
      10'h0C: begin m_pull  = d;        upd = 1; end
      10'h14: begin m_odata = d[15:0];  upd = 1; end
      10'h18: begin m_odata = (m_odata & ~d[31:16]) | d[15:0]; upd = 1; end
      10'h1C: m_lock = d[15:0];
      10'h20: m_aflo = d;
      10'h24: m_afhi = d;
      10'h28: begin m_odata = m_odata & ~d[15:0]; upd = 1; end
      10'h2C: m_asw = d[15:0];
      default: ;
    endcase
    @(negedge clk); req = 1'b0; we = 1'b0;
    check($sformatf("R9 update after wr %h", a), {31'h0, update}, {31'h0, upd});
  endtask

  // driver: one-cycle read, expected value pushed to the scoreboard
  task automatic rd(logic [AW-1:0] a, string tag);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(model_rd(a));
    tag_q.push_back($sformatf("%s rd %h", tag, a));
    @(negedge clk); req = 1'b0;
  endtask

  // monitor (R10): every valid pops one expected item
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check("R10 unexpected rvalid", 32'h1, 32'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rdata, e);
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #(8ns * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idata = 16'h5A3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_ports("R1 reset");
    check("R1 update_o", {31'h0, update}, 32'h0);
    check("R1 rvalid_o", {31'h0, rvalid}, 32'h0);
    for (int i = 0; i < 12; i++) rd(AW'(i * 4), "R1");

    // R2 full-width words, several patterns
    foreach (m_mode[i]) begin end
    for (int p = 0; p < 3; p++) begin
      automatic logic [31:0] v = (p == 0) ? 32'hDEAD_BEEF : (p == 1) ? 32'h5555_AAAA : 32'hFFFF_0001;
      wr(10'h00, v); wr(10'h08, ~v); wr(10'h0C, v ^ 32'h1234_5678);
      wr(10'h20, v + 1); wr(10'h24, v - 1);
      chk_ports("R2");
      rd(10'h00, "R2"); rd(10'h08, "R2"); rd(10'h0C, "R2");
      rd(10'h20, "R2"); rd(10'h24, "R2");
    end

    // R7 upper half discarded
    wr(10'h04, 32'hFFFF_00C3); wr(10'h14, 32'hABCD_00FF);
    wr(10'h1C, 32'h8001_1234); wr(10'h2C, 32'h7777_0F0F);
    chk_ports("R7");
    rd(10'h04, "R7"); rd(10'h14, "R7"); rd(10'h1C, "R7"); rd(10'h2C, "R7");

    // R3 set/clear, set wins
    wr(10'h18, 32'h0F0F_00F0); chk_ports("R3 mixed");
    check("R3 value", {16'h0, odata}, 32'h0000_00F0);
    wr(10'h18, 32'h0001_0001); check("R3 set wins 0->1", {31'h0, odata[0]}, 32'h1);
    wr(10'h18, 32'h0001_0001); check("R3 set wins 1->1", {31'h0, odata[0]}, 32'h1);
    wr(10'h18, 32'hFFFF_0000); check("R3 clear all", {16'h0, odata}, 32'h0);
    wr(10'h18, 32'h0000_8001); chk_ports("R3 set only");

    // R4 clear-only word
    wr(10'h14, 32'h0000_FFFF);
    wr(10'h28, 32'hFFFF_00F0); check("R4 value", {16'h0, odata}, 32'h0000_FF0F);
    chk_ports("R4");

    // R5 zero reads
    rd(10'h18, "R5"); rd(10'h28, "R5");

    // R6 input word read and write
    idata = 16'hC001; rd(10'h10, "R6");
    idata = 16'h0000; rd(10'h10, "R6");
    wr(10'h10, 32'hFFFF_FFFF); chk_ports("R6 wr ignored");

    // R11 storage-only writes leave exported state
    wr(10'h1C, 32'h0000_FFFF); wr(10'h20, 32'h0); wr(10'h24, 32'h1111_1111);
    wr(10'h2C, 32'h0000_0001); wr(10'h08, 32'h0);
    chk_ports("R11");

    // R8 unaligned and unmapped
    wr(10'h15, 32'h0000_1234); wr(10'h02, 32'h0); wr(10'h30, 32'hFFFF_FFFF);
    wr(10'h3FC, 32'hFFFF_FFFF);
    chk_ports("R8");
    rd(10'h01, "R8"); rd(10'h30, "R8"); rd(10'h3FC, "R8"); rd(10'h14, "R8 intact");

    // R9 pulse lasts one cycle
    wr(10'h00, 32'h1);
    @(negedge clk); check("R9 pulse ends", {31'h0, update}, 32'h0);

    repeat (3) @(negedge clk);
    check("R10 scoreboard drained", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule